// File: doc/BRIEF.md
# Serial Peripheral Slave Engine with Low-Power Control

This block receives and transmits bytes as the slave side of an SPI link. The external serial clock, the slave select and the serial input are first brought into the system clock domain. The block then shifts the most significant bit first. It samples the input on each rising serial clock edge and changes its output after each falling edge. When a byte is complete it moves into a receive buffer. The host reads that buffer, and it also writes a transmit buffer that the engine picks up at the start of the next byte.

The slave select line can be set to control the engine. When it does, it enables shifting and drives the serial output, and it releases that output when the line goes high. A rise of the line in the middle of a byte throws the partial byte away, so the next byte starts again at its first bit. Two host power inputs also act on the engine. Sleep aborts a byte in progress and leaves every register as it was. Idle either freezes the engine or lets it keep running, as chosen by a stop-in-idle bit in the control/status register.

The host interface has two addresses. Address 0 is the data register: a write loads the transmit buffer, and a read returns the receive buffer. Address 1 is the control/status register.

Top module: `spi_slave_pm`

## Requirements
- R1: After reset the control/status register (address 1) reads 0x0000 and the serial output enable `sdo_oe_o` is 0.
- R2: Bits are captured MSb first on rising `sck_i` edges. After the eighth bit the byte appears in the data register (address 0, bits 7:0), and the receive-full flag at bit 8 of address 1 becomes 1. A host read of address 0 clears that flag.
- R3: A byte written to address 0 is driven on `sdo_o` MSb first during the next byte, with each bit valid before the rising `sck_i` edge that samples it. When no byte is pending, zeros are driven.
- R4: If a byte completes while receive-full is still 1, the overflow flag at bit 9 of address 1 becomes 1 and the data register keeps its old byte. A host write to address 1 with bit 9 at 0 clears the overflow flag.
- R5: When slave mode (bit 0) and select control (bit 1) of address 1 are both 1, `sdo_oe_o` is 1 while `ss_n_i` is low and 0 while it is high. When select control is 0, `sdo_oe_o` is 1 whenever slave mode is 1.
- R6: With select control on, a rise of `ss_n_i` in the middle of a byte discards the partial bits. After reselection, the next eight bits form a whole byte starting from its MSb.
- R7: Asserting `sleep_i` aborts a byte in progress and ignores all serial clock edges while it is high. Address 1 and the receive buffer keep their values, and the next byte after sleep is received whole from its MSb.
- R8: The stop-in-idle bit sits at bit 13 of address 1. When it is 1 and `idle_i` is high, serial clock edges are ignored and the partial byte is held, so that it resumes after idle ends. When it is 0, the engine keeps operating while `idle_i` is high.
- R9: When slave mode (bit 0) is 0, no byte is received and `sdo_oe_o` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sck_i | input | 1 | Serial clock from the master, asynchronous, idles low |
| ss_n_i | input | 1 | Slave select, active low, asynchronous |
| sdi_i | input | 1 | Serial data in |
| sdo_o | output | 1 | Serial data out |
| sdo_oe_o | output | 1 | Output enable for the serial data pad (0 = high impedance) |
| sleep_i | input | 1 | Host sleep request |
| idle_i | input | 1 | Host idle request |
| wr_en_i | input | 1 | Host register write strobe |
| wr_addr_i | input | 1 | Host write address (0 data, 1 control/status) |
| wr_data_i | input | 16 | Host write data |
| rd_en_i | input | 1 | Host register read strobe |
| rd_addr_i | input | 1 | Host read address (0 data, 1 control/status) |
| rd_data_o | output | 16 | Host read data, combinational from `rd_addr_i` |

## Verification
The assertions assume that the host power inputs and register strobes are synchronous to `clk`. They also assume that the master keeps the serial clock low while the slave select changes, and that each serial clock phase lasts well over the depth of the synchronizer. The bench holds every `sck_i` phase for six system clocks and changes `sdi_i` only while the clock is low. It moves `ss_n_i`, `sleep_i` and `idle_i` only while `sck_i` is low, and it waits several clocks after each select change before clocking. As a result, each edge that the engine sees in its own domain matches exactly one edge driven by the bench.

// File: rtl/spi_pm_pkg.sv
// Package: shared register layout for the SPI slave engine.
// Assumes a 16-bit host register width and a one-bit address.
package spi_pm_pkg;
    localparam int REG_W        = 16;
    localparam int BIT_SLAVE    = 0;
    localparam int BIT_SSCTL    = 1;
    localparam int BIT_RXFULL   = 8;
    localparam int BIT_OVF      = 9;
    localparam int BIT_STOPIDLE = 13;
    localparam logic ADDR_DATA  = 1'b0;
    localparam logic ADDR_CTRL  = 1'b1;
endpackage

// File: rtl/spi_pm_sync.sv
// Module: multi-stage synchronizer for a vector of asynchronous inputs.
// Assumes each bit is independent (no bus coherence is needed).
module spi_pm_sync #(
    parameter int            W       = 3,
    parameter int            STAGES  = 2,
    parameter logic [W-1:0]  RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);
    logic [W-1:0] chain [STAGES];

    // Shift the asynchronous inputs through the flop chain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) chain[i] <= RST_VAL;
        end else begin
            chain[0] <= d_i;
            for (int i = 1; i < STAGES; i++) chain[i] <= chain[i-1];
        end
    end

    assign q_o = chain[STAGES-1];
endmodule

// File: rtl/spi_pm_shift.sv
// Module: serial shift engine. It holds the bit counter, the receive and
// transmit shift registers, select resynchronization, and sleep abort and
// idle freeze. Assumes synchronized inputs and the serial clock idling low.
module spi_pm_shift #(
    parameter int DATA_W = 8,
    localparam int CNT_W = $clog2(DATA_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sck_s,
    input  logic              ss_n_s,
    input  logic              sdi_s,
    input  logic              slave_en,
    input  logic              ss_ctl_en,
    input  logic              sleep_i,
    input  logic              freeze_i,
    input  logic [DATA_W-1:0] tx_word,
    output logic              sdo_o,
    output logic              sdo_oe_o,
    output logic              tx_take_o,
    output logic              rx_done_o,
    output logic [DATA_W-1:0] rx_word_o,
    output logic [CNT_W-1:0]  cnt_o,
    output logic              ss_rise_o
);
    logic              sck_q, ss_q;
    logic [CNT_W-1:0]  cnt;
    logic [DATA_W-1:0] rsr, tsr;
    logic              selected, active, sck_rise, sck_fall, resync, last_bit;

    assign selected = !ss_ctl_en || !ss_n_s;
    assign active   = slave_en && selected && !sleep_i && !freeze_i;
    assign sck_rise = sck_s && !sck_q;
    assign sck_fall = !sck_s && sck_q;
    assign ss_rise_o = ss_n_s && !ss_q;
    assign resync   = slave_en && ss_ctl_en && ss_rise_o;
    assign last_bit = (cnt == CNT_W'(DATA_W - 1));

    // Keep the previous synchronized clock and select for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sck_q <= 1'b0;
            ss_q  <= 1'b1;
        end else begin
            sck_q <= sck_s;
            ss_q  <= ss_n_s;
        end
    end

    // Count bits, shift both directions, abort on sleep or select rise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
            rsr <= '0;
            tsr <= '0;
        end else if (sleep_i || resync || !slave_en) begin
            cnt <= '0;
        end else if (active) begin
            if (sck_rise) begin
                rsr <= {rsr[DATA_W-2:0], sdi_s};
                cnt <= last_bit ? '0 : cnt + 1'b1;
            end
            if (sck_fall && cnt != '0) tsr <= {tsr[DATA_W-2:0], 1'b0};
            else if (cnt == '0)        tsr <= tx_word;
        end
    end

    assign tx_take_o = active && sck_rise && (cnt == '0);
    assign rx_done_o = active && sck_rise && last_bit;
    assign rx_word_o = {rsr[DATA_W-2:0], sdi_s};
    assign sdo_o     = tsr[DATA_W-1];
    assign sdo_oe_o  = slave_en && selected;
    assign cnt_o     = cnt;
endmodule

// File: rtl/spi_pm_regs.sv
// Module: host-visible registers. Holds control bits, the transmit buffer with
// its pending flag, and the receive buffer with full and overflow flags.
// Assumes single-cycle host strobes synchronous to clk.
module spi_pm_regs
    import spi_pm_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en_i,
    input  logic              wr_addr_i,
    input  logic [REG_W-1:0]  wr_data_i,
    input  logic              rd_en_i,
    input  logic              rd_addr_i,
    input  logic              tx_take_i,
    input  logic              rx_done_i,
    input  logic [DATA_W-1:0] rx_word_i,
    output logic [REG_W-1:0]  rd_data_o,
    output logic              slave_en_o,
    output logic              ss_ctl_en_o,
    output logic              stop_idle_o,
    output logic [DATA_W-1:0] tx_word_o,
    output logic              rx_full_o,
    output logic              ovf_o
);
    logic              wr_ctrl, wr_dat, rd_dat;
    logic [DATA_W-1:0] tx_buf, rx_buf;
    logic              tx_pend;

    assign wr_ctrl = wr_en_i && (wr_addr_i == ADDR_CTRL);
    assign wr_dat  = wr_en_i && (wr_addr_i == ADDR_DATA);
    assign rd_dat  = rd_en_i && (rd_addr_i == ADDR_DATA);

    // Control bits written by the host.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            slave_en_o  <= 1'b0;
            ss_ctl_en_o <= 1'b0;
            stop_idle_o <= 1'b0;
        end else if (wr_ctrl) begin
            slave_en_o  <= wr_data_i[BIT_SLAVE];
            ss_ctl_en_o <= wr_data_i[BIT_SSCTL];
            stop_idle_o <= wr_data_i[BIT_STOPIDLE];
        end
    end

    // Transmit buffer and its pending flag, consumed at byte start.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_buf  <= '0;
            tx_pend <= 1'b0;
        end else if (wr_dat) begin
            tx_buf  <= wr_data_i[DATA_W-1:0];
            tx_pend <= 1'b1;
        end else if (tx_take_i) begin
            tx_pend <= 1'b0;
        end
    end

    // Receive buffer with full and overflow tracking.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rx_buf    <= '0;
            rx_full_o <= 1'b0;
            ovf_o     <= 1'b0;
        end else begin
            if (rd_dat) rx_full_o <= 1'b0;
            if (wr_ctrl && !wr_data_i[BIT_OVF]) ovf_o <= 1'b0;
            if (rx_done_i) begin
                if (rx_full_o) begin
                    ovf_o <= 1'b1;
                end else begin
                    rx_buf    <= rx_word_i;
                    rx_full_o <= 1'b1;
                end
            end
        end
    end

    assign tx_word_o = tx_pend ? tx_buf : '0;

    // Read multiplexer for the two host addresses.
    always_comb begin
        rd_data_o = '0;
        if (rd_addr_i == ADDR_DATA) begin
            rd_data_o[DATA_W-1:0] = rx_buf;
        end else begin
            rd_data_o[BIT_SLAVE]    = slave_en_o;
            rd_data_o[BIT_SSCTL]    = ss_ctl_en_o;
            rd_data_o[BIT_RXFULL]   = rx_full_o;
            rd_data_o[BIT_OVF]      = ovf_o;
            rd_data_o[BIT_STOPIDLE] = stop_idle_o;
        end
    end
endmodule

// File: rtl/spi_slave_pm.sv
// Module: top of the SPI slave engine with power-mode control.
// Assumes the serial clock idles low (sample on rise, change on fall).
module spi_slave_pm
    import spi_pm_pkg::*;
#(
    parameter int DATA_W    = 8,
    parameter int SYNC_DEPTH = 2,
    localparam int CNT_W    = $clog2(DATA_W)
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        sck_i,
    input  logic        ss_n_i,
    input  logic        sdi_i,
    output logic        sdo_o,
    output logic        sdo_oe_o,
    input  logic        sleep_i,
    input  logic        idle_i,
    input  logic        wr_en_i,
    input  logic        wr_addr_i,
    input  logic [15:0] wr_data_i,
    input  logic        rd_en_i,
    input  logic        rd_addr_i,
    output logic [15:0] rd_data_o
);
    logic              sck_s, ss_n_s, sdi_s;
    logic              slave_en, ss_ctl_en, stop_idle, freeze;
    logic              tx_take, rx_done, rx_full, ovf, ss_rise;
    logic [DATA_W-1:0] tx_word, rx_word;
    logic [CNT_W-1:0]  cnt;
    logic              rd_clr, ovf_clr;

    assign freeze  = idle_i && stop_idle;
    assign rd_clr  = rd_en_i && (rd_addr_i == ADDR_DATA);
    assign ovf_clr = wr_en_i && (wr_addr_i == ADDR_CTRL) && !wr_data_i[BIT_OVF];

    spi_pm_sync #(.W(3), .STAGES(SYNC_DEPTH), .RST_VAL(3'b010)) i_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   ({sck_i, ss_n_i, sdi_i}),
        .q_o   ({sck_s, ss_n_s, sdi_s})
    );

    spi_pm_shift #(.DATA_W(DATA_W)) i_shift (
        .clk       (clk),
        .rst_n     (rst_n),
        .sck_s     (sck_s),
        .ss_n_s    (ss_n_s),
        .sdi_s     (sdi_s),
        .slave_en  (slave_en),
        .ss_ctl_en (ss_ctl_en),
        .sleep_i   (sleep_i),
        .freeze_i  (freeze),
        .tx_word   (tx_word),
        .sdo_o     (sdo_o),
        .sdo_oe_o  (sdo_oe_o),
        .tx_take_o (tx_take),
        .rx_done_o (rx_done),
        .rx_word_o (rx_word),
        .cnt_o     (cnt),
        .ss_rise_o (ss_rise)
    );

    spi_pm_regs #(.DATA_W(DATA_W)) i_regs (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_en_i     (wr_en_i),
        .wr_addr_i   (wr_addr_i),
        .wr_data_i   (wr_data_i),
        .rd_en_i     (rd_en_i),
        .rd_addr_i   (rd_addr_i),
        .tx_take_i   (tx_take),
        .rx_done_i   (rx_done),
        .rx_word_i   (rx_word),
        .rd_data_o   (rd_data_o),
        .slave_en_o  (slave_en),
        .ss_ctl_en_o (ss_ctl_en),
        .stop_idle_o (stop_idle),
        .tx_word_o   (tx_word),
        .rx_full_o   (rx_full),
        .ovf_o       (ovf)
    );
endmodule

// File: rtl/spi_pm_checker.sv
// Module: property checker for spi_slave_pm, attached through bind.
// Assumes host strobes and power inputs are synchronous to clk.
module spi_pm_checker #(
    parameter int CNT_W = 3
) (
    input logic             clk,
    input logic             rst_n,
    input logic             slave_en,
    input logic             ss_ctl_en,
    input logic             ss_n_s,
    input logic             ss_rise,
    input logic             sdo_oe,
    input logic             sleep_i,
    input logic             freeze,
    input logic [CNT_W-1:0] cnt,
    input logic             rx_full,
    input logic             ovf,
    input logic             rd_clr,
    input logic             ovf_clr
);
    a_r5_oe_released: assert property (@(posedge clk) disable iff (!rst_n)
        (slave_en && ss_ctl_en && ss_n_s) |-> !sdo_oe);
    a_r5_oe_driven: assert property (@(posedge clk) disable iff (!rst_n)
        (slave_en && ss_ctl_en && !ss_n_s) |-> sdo_oe);
    a_r9_no_drive_off: assert property (@(posedge clk) disable iff (!rst_n)
        !slave_en |-> !sdo_oe);
    a_r6_resync_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (slave_en && ss_ctl_en && ss_rise) |=> (cnt == '0));
    a_r7_sleep_aborts: assert property (@(posedge clk) disable iff (!rst_n)
        sleep_i |=> (cnt == '0));
    a_r8_freeze_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (freeze && slave_en && !sleep_i && !ss_rise) |=> $stable(cnt));
    a_r2_full_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_full && !rd_clr) |=> rx_full);
    a_r4_ovf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf && !ovf_clr) |=> ovf);
endmodule

bind spi_slave_pm spi_pm_checker #(.CNT_W(CNT_W)) i_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .slave_en  (slave_en),
    .ss_ctl_en (ss_ctl_en),
    .ss_n_s    (ss_n_s),
    .ss_rise   (ss_rise),
    .sdo_oe    (sdo_oe_o),
    .sleep_i   (sleep_i),
    .freeze    (freeze),
    .cnt       (cnt),
    .rx_full   (rx_full),
    .ovf       (ovf),
    .rd_clr    (rd_clr),
    .ovf_clr   (ovf_clr)
);

// File: tb/test_spi_slave_pm.sv
// Bench: directed scenarios for spi_slave_pm, one task each.
module test_spi_slave_pm;
    localparam int HALF = 6;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sck = 1'b0, ss_n = 1'b1, sdi = 1'b0;
    logic        sdo, sdo_oe;
    logic        sleep = 1'b0, idle = 1'b0;
    logic        wr_en = 1'b0, wr_addr = 1'b0, rd_en = 1'b0, rd_addr = 1'b0;
    logic [15:0] wr_data = '0, rd_data;
    int          n_chk = 0, n_bad = 0;
    bit          done = 1'b0;

    always #2.5 clk = ~clk;

    spi_slave_pm i_spi_slave_pm (
        .clk(clk), .rst_n(rst_n), .sck_i(sck), .ss_n_i(ss_n), .sdi_i(sdi),
        .sdo_o(sdo), .sdo_oe_o(sdo_oe), .sleep_i(sleep), .idle_i(idle),
        .wr_en_i(wr_en), .wr_addr_i(wr_addr), .wr_data_i(wr_data),
        .rd_en_i(rd_en), .rd_addr_i(rd_addr), .rd_data_o(rd_data)
    );

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic host_wr(input logic a, input logic [15:0] d);
        @(negedge clk); wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk); wr_en = 1'b0;
    endtask

    task automatic host_rd(input logic a, output logic [15:0] d);
        @(negedge clk); rd_en = 1'b1; rd_addr = a;
        #1 d = rd_data;
        @(negedge clk); rd_en = 1'b0;
    endtask

    task automatic set_ss(input logic v);
        @(negedge clk); ss_n = v;
        repeat (HALF) @(negedge clk);
    endtask

    task automatic spi_bit(input logic b, output logic got);
        @(negedge clk); sdi = b;
        repeat (HALF) @(negedge clk);
        got = sdo;
        sck = 1'b1;
        repeat (HALF) @(negedge clk);
        sck = 1'b0;
    endtask

    task automatic spi_byte(input logic [7:0] din, output logic [7:0] dout);
        for (int i = 7; i >= 0; i--) spi_bit(din[i], dout[i]);
        repeat (HALF) @(negedge clk);
    endtask

    task automatic t_reset();
        logic [15:0] d;
        host_rd(1'b1, d);
        check("R1 ctrl after reset", d, 16'h0000);
        check("R1 oe after reset", {15'b0, sdo_oe}, 16'h0000);
    endtask

    task automatic t_basic();
        logic [15:0] d; logic [7:0] o;
        host_wr(1'b1, 16'h0003);
        check("R5 oe with select high", {15'b0, sdo_oe}, 16'h0000);
        set_ss(1'b0);
        check("R5 oe with select low", {15'b0, sdo_oe}, 16'h0001);
        host_wr(1'b0, 16'h00A5);
        spi_byte(8'h3C, o);
        check("R3 tx byte on sdo", {8'h0, o}, 16'h00A5);
        host_rd(1'b1, d);
        check("R2 rx full set", {15'b0, d[8]}, 16'h0001);
        host_rd(1'b0, d);
        check("R2 rx data", d, 16'h003C);
        host_rd(1'b1, d);
        check("R2 rx full cleared by read", {15'b0, d[8]}, 16'h0000);
        spi_byte(8'h81, o);
        check("R3 zeros when nothing written", {8'h0, o}, 16'h0000);
    endtask

    task automatic t_overflow();
        logic [15:0] d; logic [7:0] o;
        spi_byte(8'h55, o);
        host_rd(1'b1, d);
        check("R4 overflow set", {15'b0, d[9]}, 16'h0001);
        host_rd(1'b0, d);
        check("R4 buffer kept", d, 16'h0081);
        host_wr(1'b1, 16'h0003);
        host_rd(1'b1, d);
        check("R4 overflow cleared", {15'b0, d[9]}, 16'h0000);
    endtask

    task automatic t_deselect();
        logic [15:0] d; logic [7:0] o; logic g;
        spi_bit(1'b1, g); spi_bit(1'b1, g); spi_bit(1'b1, g);
        set_ss(1'b1);
        check("R5 oe released when deselected", {15'b0, sdo_oe}, 16'h0000);
        set_ss(1'b0);
        spi_byte(8'h4B, o);
        host_rd(1'b0, d);
        check("R6 whole byte after reselect", d, 16'h004B);
    endtask

    task automatic t_sleep();
        logic [15:0] d; logic [7:0] o; logic g;
        spi_bit(1'b0, g); spi_bit(1'b1, g); spi_bit(1'b1, g);
        @(negedge clk); sleep = 1'b1;
        spi_bit(1'b1, g); spi_bit(1'b0, g);
        @(negedge clk); sleep = 1'b0;
        repeat (HALF) @(negedge clk);
        host_rd(1'b1, d);
        check("R7 ctrl kept over sleep", d, 16'h0003);
        host_rd(1'b0, d);
        check("R7 rx buffer kept over sleep", d, 16'h004B);
        spi_byte(8'hE7, o);
        host_rd(1'b0, d);
        check("R7 fresh byte after sleep", d, 16'h00E7);
    endtask

    task automatic t_idle();
        logic [15:0] d; logic [7:0] o; logic g;
        host_wr(1'b1, 16'h2003);
        host_rd(1'b1, d);
        check("R8 stop-in-idle bit 13", d, 16'h2003);
        spi_bit(1'b1, g); spi_bit(1'b0, g); spi_bit(1'b1, g);
        @(negedge clk); idle = 1'b1;
        for (int i = 0; i < 5; i++) spi_bit(1'b1, g);
        @(negedge clk); idle = 1'b0;
        spi_bit(1'b1, g); spi_bit(1'b0, g); spi_bit(1'b1, g);
        spi_bit(1'b0, g); spi_bit(1'b0, g);
        repeat (HALF) @(negedge clk);
        host_rd(1'b0, d);
        check("R8 frozen during idle", d, 16'h00B4);
        host_wr(1'b1, 16'h0003);
        @(negedge clk); idle = 1'b1;
        spi_byte(8'h5A, o);
        @(negedge clk); idle = 1'b0;
        host_rd(1'b0, d);
        check("R8 runs during idle", d, 16'h005A);
    endtask

    task automatic t_slave_off();
        logic [15:0] d; logic [7:0] o;
        host_wr(1'b1, 16'h0002);
        check("R9 oe off when not slave", {15'b0, sdo_oe}, 16'h0000);
        spi_byte(8'hFF, o);
        host_rd(1'b1, d);
        check("R9 no reception when not slave", {15'b0, d[8]}, 16'h0000);
        host_rd(1'b0, d);
        check("R9 buffer untouched", d, 16'h005A);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        t_reset();
        t_basic();
        t_overflow();
        t_deselect();
        t_sleep();
        t_idle();
        t_slave_off();
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule